// File: doc/BRIEF.md
# Hart Run-Control Register Block

This block gives a debugger run control over a small group of harts through a plain register bus with an address, write data, read data and separate read and write strobes. It has two registers. The control register at address 0x10 carries halt, resume, hart-reset and reset-acknowledge requests. Each request acts on the harts picked by the selection fields carried in that same write. The status register at address 0x11 reports resume-acknowledge and have-reset conditions, reduced to an "any" flag and an "all" flag over the currently selected harts. It also holds a sticky three-bit access-error code.

Each hart is modelled as a halted/running state with a reset line driven by the block. A hart that leaves reset raises a have-reset flag. The flag stays up until the debugger acknowledges it, so a debugger can detect resets that happened while it was not polling. An access to an address with no register records an error code. That code stays set until the debugger writes ones over it.

Top module: `hartRunCtl`

## Requirements
- R1: After reset every hart is running and out of reset, and both registers read as all zeros.
- R2: A control write with bit 31 set halts every selected running hart on the following cycle. Harts that are not selected keep their state. A control write with bit 31 clear changes no hart's halted state.
- R3: A control write with bit 30 set and bit 31 clear resumes every selected halted hart. When bit 31 is also set, bit 30 is ignored: no hart resumes and no resume-acknowledge flag changes.
- R4: Control bit 29 is written to the reset line of each selected hart. A 1 asserts the reset and a 0 releases it. A hart held in reset reads as running (hartHalted low).
- R5: A hart whose reset is released sets its have-reset flag. A control write with bit 28 set clears the flag of each selected hart. If one write both releases a hart's reset and sets bit 28, that hart's flag ends up set.
- R6: Status bit 18 is 1 when at least one selected hart has its have-reset flag set. Status bit 19 is 1 when at least one hart is selected and every selected hart has its flag set.
- R7: An accepted resume request sets the resume-acknowledge flag of each selected hart that is not in reset, and clears it for a selected hart in reset. Status bit 16 is the "any" reduction over selected harts and bit 17 is the "all" reduction.
- R8: Control bits [SEL_W-1:0] hold a hart index and bit 26 selects every hart. An index at or above the hart count selects no hart, and then all four status flags read 0. Requests act on the selection carried by the same write.
- R9: Status bits 26:24 hold the error code. A read or write to an address other than 0x10 or 0x11 records 1. A cycle with both strobes high records 7 and changes no register. The code is only recorded while the field is 0, and otherwise the field holds its value.
- R10: A write to the status register clears every error bit that is written as 1 in bits 26:24. The other error bits keep their value.
- R11: Read data is registered. It appears on the cycle after the read strobe and holds until the next read. A control read returns the selection fields and, in bit 29, whether any selected hart is in reset. The request bits 31, 30 and 28 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 7 | Register address |
| busWdata | input | 32 | Write data |
| busWrite | input | 1 | Write strobe |
| busRead | input | 1 | Read strobe |
| busRdata | output | 32 | Registered read data |
| hartHalted | output | NHARTS | Halted state per hart |
| hartReset | output | NHARTS | Reset line per hart |

## Verification
Two pairs of actions can land in the same write. The first pair is a hart's reset release and an acknowledge of its have-reset flag. The bench provokes this with one control write that carries reset 0 and the acknowledge bit for a hart held in reset, and expects the status to still show the flag set. The second pair is halt and resume in one write. Here the bench expects the selected hart to stay halted and its resume-acknowledge flag to stay at its earlier value.

// File: rtl/hartRunPkg.sv
package hartRunPkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] CTL_ADDR  = 7'h10;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 7'h11;

  localparam int HALT_BIT   = 31;
  localparam int RESUME_BIT = 30;
  localparam int RESET_BIT  = 29;
  localparam int ACK_BIT    = 28;
  localparam int GROUP_BIT  = 26;
  localparam int ERR_LO     = 24;
  localparam int HR_ALL_BIT = 19;
  localparam int HR_ANY_BIT = 18;
  localparam int RA_ALL_BIT = 17;
  localparam int RA_ANY_BIT = 16;

  localparam logic [2:0] ERR_NONE    = 3'd0;
  localparam logic [2:0] ERR_BADADDR = 3'd1;
  localparam logic [2:0] ERR_OTHER   = 3'd7;

  typedef struct packed {
    logic       ctlWr;
    logic       statWr;
    logic       haltGo;
    logic       resumeGo;
    logic       ackGo;
    logic       resetVal;
    logic       groupSel;
    logic       rdAny;
    logic       rdCtl;
    logic       rdStat;
    logic       errHit;
    logic [2:0] errCode;
    logic [2:0] errClr;
  } strobeT;
endpackage

// File: rtl/hartRunDecode.sv
module hartRunDecode
  import hartRunPkg::*;
#(
  parameter int NHARTS = 4,
  parameter int SEL_W  = 4
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWrite,
  input  logic              busRead,
  output strobeT            stb,
  output logic [SEL_W-1:0]  wrIdx,
  output logic [NHARTS-1:0] wrMask
);
  logic isCtl, isStat;
  logic unusedBits;

  assign isCtl      = (busAddr == CTL_ADDR);
  assign isStat     = (busAddr == STAT_ADDR);
  assign wrIdx      = busWdata[SEL_W-1:0];
  assign unusedBits = ^{busWdata[27], busWdata[23:SEL_W]};

  always_comb begin
    stb          = '0;
    stb.rdAny    = busRead;
    stb.resetVal = busWdata[RESET_BIT];
    stb.groupSel = busWdata[GROUP_BIT];
    stb.errClr   = busWdata[ERR_LO+2:ERR_LO];
    if (busWrite && busRead) begin
      stb.errHit  = 1'b1;
      stb.errCode = ERR_OTHER;
    end else if (busWrite || busRead) begin
      if (!isCtl && !isStat) begin
        stb.errHit  = 1'b1;
        stb.errCode = ERR_BADADDR;
      end else begin
        stb.ctlWr  = busWrite && isCtl;
        stb.statWr = busWrite && isStat;
        stb.rdCtl  = busRead && isCtl;
        stb.rdStat = busRead && isStat;
      end
    end
    stb.haltGo   = stb.ctlWr && busWdata[HALT_BIT];
    stb.resumeGo = stb.ctlWr && busWdata[RESUME_BIT] && !busWdata[HALT_BIT];
    stb.ackGo    = stb.ctlWr && busWdata[ACK_BIT];
  end

  for (genvar i = 0; i < NHARTS; i++) begin : g_mask
    assign wrMask[i] = busWdata[GROUP_BIT] || (wrIdx == SEL_W'(i));
  end
endmodule

// File: rtl/hartRunState.sv
module hartRunState
  import hartRunPkg::*;
#(
  parameter int NHARTS = 4,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [SEL_W-1:0]  wrIdx,
  input  logic [NHARTS-1:0] wrMask,
  output logic [NHARTS-1:0] hartHalted,
  output logic [NHARTS-1:0] hartReset,
  output logic [DATA_W-1:0] busRdata,
  output logic [2:0]        errField,
  output logic              hrAny,
  output logic              hrAll,
  output logic              raAny,
  output logic              raAll
);
  logic [NHARTS-1:0] halted, inReset, haveReset, resumeAck;
  logic [NHARTS-1:0] resetNext, selMask;
  logic [SEL_W-1:0]  selIdx;
  logic              groupSel;
  logic [2:0]        err;
  logic [DATA_W-1:0] ctlView, statView;

  for (genvar i = 0; i < NHARTS; i++) begin : g_sel
    assign selMask[i]   = groupSel || (selIdx == SEL_W'(i));
    assign resetNext[i] = (stb.ctlWr && wrMask[i]) ? stb.resetVal : inReset[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halted    <= '0;
      inReset   <= '0;
      haveReset <= '0;
      resumeAck <= '0;
    end else begin
      inReset <= resetNext;
      for (int i = 0; i < NHARTS; i++) begin
        if (resetNext[i])                      halted[i] <= 1'b0;
        else if (stb.haltGo && wrMask[i])      halted[i] <= 1'b1;
        else if (stb.resumeGo && wrMask[i])    halted[i] <= 1'b0;

        if (stb.ctlWr && wrMask[i] && inReset[i] && !stb.resetVal)
          haveReset[i] <= 1'b1;
        else if (stb.ackGo && wrMask[i])
          haveReset[i] <= 1'b0;

        if (stb.resumeGo && wrMask[i])
          resumeAck[i] <= !resetNext[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selIdx   <= '0;
      groupSel <= 1'b0;
      err      <= ERR_NONE;
    end else begin
      if (stb.ctlWr) begin
        selIdx   <= wrIdx;
        groupSel <= stb.groupSel;
      end
      if (stb.errHit && err == ERR_NONE) err <= stb.errCode;
      else if (stb.statWr)               err <= err & ~stb.errClr;
    end
  end

  assign hrAny = |(haveReset & selMask);
  assign hrAll = (|selMask) && ((haveReset & selMask) == selMask);
  assign raAny = |(resumeAck & selMask);
  assign raAll = (|selMask) && ((resumeAck & selMask) == selMask);

  always_comb begin
    ctlView                 = '0;
    ctlView[RESET_BIT]      = |(inReset & selMask);
    ctlView[GROUP_BIT]      = groupSel;
    ctlView[SEL_W-1:0]      = selIdx;
    statView                = '0;
    statView[ERR_LO+2:ERR_LO] = err;
    statView[HR_ALL_BIT]    = hrAll;
    statView[HR_ANY_BIT]    = hrAny;
    statView[RA_ALL_BIT]    = raAll;
    statView[RA_ANY_BIT]    = raAny;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          busRdata <= '0;
    else if (stb.rdAny) busRdata <= stb.rdCtl ? ctlView : (stb.rdStat ? statView : '0);
  end

  assign hartHalted = halted;
  assign hartReset  = inReset;
  assign errField   = err;
endmodule

// File: rtl/hartRunCtl.sv
module hartRunCtl
  import hartRunPkg::*;
#(
  parameter int NHARTS = 4,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [6:0]        busAddr,
  input  logic [31:0]       busWdata,
  input  logic              busWrite,
  input  logic              busRead,
  output logic [31:0]       busRdata,
  output logic [NHARTS-1:0] hartHalted,
  output logic [NHARTS-1:0] hartReset
);
  strobeT            stb;
  logic [SEL_W-1:0]  wrIdx;
  logic [NHARTS-1:0] wrMask;
  logic [2:0]        errField;
  logic              hrAny, hrAll, raAny, raAll;

  hartRunDecode #(.NHARTS(NHARTS), .SEL_W(SEL_W)) u_decode (
    .busAddr(busAddr), .busWdata(busWdata), .busWrite(busWrite), .busRead(busRead),
    .stb(stb), .wrIdx(wrIdx), .wrMask(wrMask)
  );

  hartRunState #(.NHARTS(NHARTS), .SEL_W(SEL_W)) u_state (
    .clk(clk), .rstN(rstN), .stb(stb), .wrIdx(wrIdx), .wrMask(wrMask),
    .hartHalted(hartHalted), .hartReset(hartReset), .busRdata(busRdata),
    .errField(errField), .hrAny(hrAny), .hrAll(hrAll), .raAny(raAny), .raAll(raAll)
  );
endmodule

// File: rtl/hartRunCtlChk.sv
module hartRunCtlChk
  import hartRunPkg::*;
#(
  parameter int NHARTS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              busRead,
  input logic [31:0]       busRdata,
  input strobeT            stb,
  input logic [NHARTS-1:0] wrMask,
  input logic [NHARTS-1:0] hartHalted,
  input logic [NHARTS-1:0] hartReset,
  input logic [2:0]        errField,
  input logic              hrAny,
  input logic              hrAll,
  input logic              raAny,
  input logic              raAll
);
  assert_halt_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.haltGo && !stb.resetVal) |=> ((hartHalted & $past(wrMask)) == $past(wrMask)));

  assert_resume_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.resumeGo && !stb.resetVal) |=> ((hartHalted & $past(wrMask)) == '0));

  assert_reset_run_R4: assert property (@(posedge clk) disable iff (!rstN)
    (hartHalted & hartReset) == '0);

  assert_hr_all_any_R6: assert property (@(posedge clk) disable iff (!rstN)
    hrAll |-> hrAny);

  assert_ra_all_any_R7: assert property (@(posedge clk) disable iff (!rstN)
    raAll |-> raAny);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (errField != 3'd0 && !stb.statWr) |=> (errField == $past(errField)));

  assert_err_record_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.errHit && errField == 3'd0) |=> (errField == $past(stb.errCode)));

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !busRead |=> $stable(busRdata));
endmodule

bind hartRunCtl hartRunCtlChk #(.NHARTS(NHARTS)) u_chk (
  .clk(clk), .rstN(rstN), .busRead(busRead), .busRdata(busRdata),
  .stb(stb), .wrMask(wrMask), .hartHalted(hartHalted), .hartReset(hartReset),
  .errField(errField), .hrAny(hrAny), .hrAll(hrAll), .raAny(raAny), .raAll(raAll)
);

// File: tb/hartRunCtl_bench.sv
module hartRunCtl_bench;
  localparam int NH = 4;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [6:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic busWrite = 1'b0, busRead = 1'b0;
  logic [31:0] busRdata;
  logic [NH-1:0] hartHalted, hartReset;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hartRunCtl #(.NHARTS(NH), .SEL_W(4)) u_hartRunCtl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWrite(busWrite), .busRead(busRead), .busRdata(busRdata),
    .hartHalted(hartHalted), .hartReset(hartReset)
  );

  function automatic logic [31:0] ctlWord(bit h, bit r, bit rst, bit ack, bit grp, logic [3:0] idx);
    logic [31:0] w = '0;
    w[31] = h; w[30] = r; w[29] = rst; w[28] = ack; w[26] = grp; w[3:0] = idx;
    return w;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk); busWrite = 1'b0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; busRead = 1'b1;
    @(negedge clk); busRead = 1'b0; d = busRdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 halted", 32'(hartHalted), 32'h0);
    check("R1 reset lines", 32'(hartReset), 32'h0);
    rd(7'h11, v); check("R1 status", v, 32'h0);
    rd(7'h10, v); check("R1 control", v, 32'h0);
  endtask

  task automatic t_halt;
    wr(7'h10, ctlWord(1, 0, 0, 0, 0, 4'd1));
    check("R2 halt hart1", 32'(hartHalted), 32'h2);
    wr(7'h10, ctlWord(1, 0, 0, 0, 0, 4'd3));
    check("R2 halt hart3 only", 32'(hartHalted), 32'ha);
    wr(7'h10, ctlWord(0, 0, 0, 0, 0, 4'd1));
    check("R2 zero write no effect", 32'(hartHalted), 32'ha);
  endtask

  task automatic t_resume;
    logic [31:0] v;
    wr(7'h10, ctlWord(1, 1, 0, 0, 0, 4'd1));
    check("R3 resume ignored under halt", 32'(hartHalted), 32'ha);
    rd(7'h11, v); check("R3 no ack when ignored", 32'(v[17:16]), 32'h0);
    wr(7'h10, ctlWord(0, 1, 0, 0, 0, 4'd1));
    check("R3 resume hart1", 32'(hartHalted), 32'h8);
    rd(7'h11, v); check("R7 ack any/all hart1", 32'(v[17:16]), 32'h3);
    wr(7'h10, ctlWord(0, 0, 0, 0, 1, 4'd0));
    rd(7'h11, v); check("R7 group any only", 32'(v[17:16]), 32'h1);
    check("R8 group no-op keeps harts", 32'(hartHalted), 32'h8);
  endtask

  task automatic t_outOfRange;
    logic [31:0] v;
    wr(7'h10, ctlWord(1, 0, 0, 0, 0, 4'd9));
    check("R8 index 9 selects none", 32'(hartHalted), 32'h8);
    rd(7'h11, v); check("R8 flags zero when none", 32'(v[19:16]), 32'h0);
    rd(7'h10, v); check("R11 control readback", v, 32'h9);
  endtask

  task automatic t_resetFlow;
    logic [31:0] v;
    wr(7'h10, ctlWord(0, 0, 1, 0, 1, 4'd0));
    check("R4 all in reset", 32'(hartReset), 32'hf);
    check("R4 reset forces running", 32'(hartHalted), 32'h0);
    rd(7'h10, v); check("R11 control reset bit", v, 32'h2400_0000);
    wr(7'h10, ctlWord(0, 0, 0, 0, 1, 4'd0));
    check("R4 release", 32'(hartReset), 32'h0);
    rd(7'h11, v); check("R6 all have reset", 32'(v[19:18]), 32'h3);
    wr(7'h10, ctlWord(0, 0, 0, 1, 0, 4'd2));
    rd(7'h11, v); check("R5 ack clears hart2", 32'(v[19:18]), 32'h0);
    wr(7'h10, ctlWord(0, 0, 0, 0, 1, 4'd0));
    rd(7'h11, v); check("R6 any not all", 32'(v[19:18]), 32'h1);
    wr(7'h10, ctlWord(0, 0, 0, 1, 0, 4'd0));
    wr(7'h10, ctlWord(0, 0, 1, 0, 0, 4'd0));
    check("R4 hart0 reset", 32'(hartReset), 32'h1);
    wr(7'h10, ctlWord(0, 1, 0, 0, 0, 4'd0));
    wr(7'h10, ctlWord(0, 0, 1, 0, 0, 4'd0));
    wr(7'h10, ctlWord(0, 1, 1, 0, 0, 4'd0));
    rd(7'h11, v); check("R7 resume in reset clears ack", 32'(v[17:16]), 32'h0);
    wr(7'h10, ctlWord(0, 0, 0, 1, 0, 4'd0));
    rd(7'h11, v); check("R5 release+ack keeps flag", 32'(v[19:18]), 32'h3);
    wr(7'h10, ctlWord(0, 0, 0, 1, 0, 4'd0));
    rd(7'h11, v); check("R5 ack clears hart0", 32'(v[19:18]), 32'h0);
  endtask

  task automatic t_error;
    logic [31:0] v;
    rd(7'h12, v); check("R11 bad read data zero", v, 32'h0);
    rd(7'h11, v); check("R9 bad address code", 32'(v[26:24]), 32'h1);
    wr(7'h05, 32'h0);
    rd(7'h11, v); check("R9 sticky", 32'(v[26:24]), 32'h1);
    wr(7'h11, 32'h0100_0000);
    rd(7'h11, v); check("R10 clear", 32'(v[26:24]), 32'h0);
    @(negedge clk); busAddr = 7'h10; busWdata = ctlWord(1, 0, 0, 0, 1, 4'd0);
    busWrite = 1'b1; busRead = 1'b1;
    @(negedge clk); busWrite = 1'b0; busRead = 1'b0;
    check("R9 dual strobe ignored", 32'(hartHalted), 32'h0);
    rd(7'h11, v); check("R9 dual strobe code", 32'(v[26:24]), 32'h7);
    check("R11 rdata holds", busRdata, v);
    wr(7'h11, 32'h0200_0000);
    rd(7'h11, v); check("R10 partial clear", 32'(v[26:24]), 32'h5);
    wr(7'h11, 32'h0700_0000);
    rd(7'h11, v); check("R10 full clear", 32'(v[26:24]), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_halt();
    t_resume();
    t_outOfRange();
    t_resetFlow();
    t_error();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule